// File: doc/BRIEF.md
# Capture Configuration Decoder and Sample Strobe Divider

This block sits behind a host command endpoint of a logic-capture front end. It takes a stream of configuration bytes and frames them into register writes and register reads, keeping a small register file. Writes are four bytes long. Reads are three bytes long and return one reply byte on a separate response stream.

Two settings in the register file drive the capture path. The first is a 16-bit channel-enable mask, stored as two bytes. The second is a sample-rate setting. A select byte chooses one of two base-clock enable pulse trains, the slow base or the fast base. A divide count N then thins the chosen train, so that one sample strobe is produced for every N+1 base pulses. Software programs the select byte and the divide count together to reach a given rate. For example, a slow base of 100 MHz with N=0xc7 gives 500 kHz, and a fast base of 160 MHz with N=0x13 gives 8 MHz.

Top module: `lacfg_top`

## Requirements
- R1: A write is the byte sequence 0x80, 0x01, address, data. The addressed register takes the data byte on the clock edge that accepts the fourth byte, and not earlier.
- R2: A read is the byte sequence 0x81, 0x01, address. It produces exactly one reply byte holding that register's current value. Addresses with no register reply 0x00.
- R3: A reply holds rsp_valid and rsp_data steady until rsp_ready is seen. While a reply is pending, cmd_ready is low. rsp_valid rises in the cycle after the address byte is accepted.
- R4: chan_mask[7:0] is register 0x02 and chan_mask[15:8] is register 0x03. A write to an address that has no register changes nothing.
- R5: In the opcode slot, any byte other than 0x80 or 0x81 is discarded. If the second byte is not 0x01, the frame is dropped. When that second byte is 0x80 or 0x81, it starts a new frame of that kind.
- R6: sample_stb is a one-cycle pulse. It fires once for every N+1 pulses of the selected base enable, where N is register 0x04. No strobe occurs while no base pulse arrives.
- R7: Register 0x0a selects the base enable. Zero selects tick_slow and any nonzero value selects tick_fast. The base that is not selected has no effect.
- R8: A write to register 0x04 or 0x0a restarts the division. A base pulse in the cycle of that write is not counted. The first strobe after the write follows the (N+1)th later pulse.
- R9: After reset, all registers read 0x00, chan_mask is zero, cmd_ready is high and rsp_valid is low. The divider then strobes on every tick_slow pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_data | input | 8 | Command byte |
| cmd_ready | output | 1 | Command byte can be accepted |
| rsp_valid | output | 1 | Reply byte pending |
| rsp_data | output | 8 | Reply byte |
| rsp_ready | input | 1 | Consumer takes the reply byte |
| tick_slow | input | 1 | Slow base-clock enable pulse |
| tick_fast | input | 1 | Fast base-clock enable pulse |
| chan_mask | output | 16 | Channel-enable mask |
| sample_stb | output | 1 | Sample strobe, one cycle wide |

## Verification
A divider reload and a base-clock pulse can land in the same cycle. The bench provokes this by holding the slow enable high on every cycle while the data byte of a divide-count write is accepted. The pass condition is that the first strobe appears on the third sampled cycle after the write, not the second. A pending reply can also meet a command byte offered in the same cycle. The bench holds rsp_ready low with bytes waiting and judges that cmd_ready stays low and the reply byte stays unchanged.

// File: rtl/lacfg_pkg.sv
package lacfg_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_WRITE       = 8'h80;
  localparam logic [BYTE_W-1:0] OP_READ        = 8'h81;
  localparam logic [BYTE_W-1:0] SUB_CODE       = 8'h01;

  localparam logic [BYTE_W-1:0] ADDR_MASK_BASE = 8'h02;
  localparam logic [BYTE_W-1:0] ADDR_DIV       = 8'h04;
  localparam logic [BYTE_W-1:0] ADDR_SEL       = 8'h0a;

  typedef enum logic [2:0] {
    PS_OPCODE,
    PS_SUB,
    PS_ADDR,
    PS_DATA,
    PS_REPLY
  } pstate_e;

endpackage

// File: rtl/lacfg_parser.sv
module lacfg_parser
  import lacfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  input  logic              rsp_ready
);

  pstate_e           st_q;
  logic              is_wr_q;
  logic [BYTE_W-1:0] addr_q;
  logic              take;

  assign in_ready = (st_q != PS_REPLY);
  assign take     = in_valid && in_ready;
  assign wr_en    = take && (st_q == PS_DATA);
  assign wr_addr  = addr_q;
  assign wr_data  = in_data;
  assign rd_addr  = in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PS_OPCODE;
      is_wr_q   <= 1'b0;
      addr_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      case (st_q)
        PS_OPCODE: begin
          if (take) begin
            if (in_data == OP_WRITE) begin
              is_wr_q <= 1'b1;
              st_q    <= PS_SUB;
            end else if (in_data == OP_READ) begin
              is_wr_q <= 1'b0;
              st_q    <= PS_SUB;
            end
          end
        end
        PS_SUB: begin
          if (take) begin
            if (in_data == SUB_CODE) begin
              st_q <= PS_ADDR;
            end else if (in_data == OP_WRITE) begin
              is_wr_q <= 1'b1;
            end else if (in_data == OP_READ) begin
              is_wr_q <= 1'b0;
            end else begin
              st_q <= PS_OPCODE;
            end
          end
        end
        PS_ADDR: begin
          if (take) begin
            if (is_wr_q) begin
              addr_q <= in_data;
              st_q   <= PS_DATA;
            end else begin
              rsp_data  <= rd_data;
              rsp_valid <= 1'b1;
              st_q      <= PS_REPLY;
            end
          end
        end
        PS_DATA: begin
          if (take) st_q <= PS_OPCODE;
        end
        PS_REPLY: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            st_q      <= PS_OPCODE;
          end
        end
        default: st_q <= PS_OPCODE;
      endcase
    end
  end

  // R3
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R3
  rsp_block_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !in_ready);

endmodule

// File: rtl/lacfg_regfile.sv
module lacfg_regfile
  import lacfg_pkg::*;
#(
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [MASK_W-1:0] chan_mask,
  output logic [BYTE_W-1:0] div_n,
  output logic              base_sel,
  output logic              reload
);

  localparam int MASK_BYTES = MASK_W / BYTE_W;

  logic [BYTE_W-1:0] mask_q [MASK_BYTES];
  logic [BYTE_W-1:0] div_q;
  logic [BYTE_W-1:0] sel_q;

  for (genvar gi = 0; gi < MASK_BYTES; gi++) begin : g_mask
    localparam logic [BYTE_W-1:0] ADDR_I = BYTE_W'(32'(ADDR_MASK_BASE) + gi);
    always_ff @(posedge clk) begin
      if (rst)                            mask_q[gi] <= '0;
      else if (wr_en && wr_addr == ADDR_I) mask_q[gi] <= wr_data;
    end
    assign chan_mask[gi*BYTE_W +: BYTE_W] = mask_q[gi];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sel_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_DIV) div_q <= wr_data;
      if (wr_addr == ADDR_SEL) sel_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_DIV) rd_data = div_q;
    if (rd_addr == ADDR_SEL) rd_data = sel_q;
    for (int i = 0; i < MASK_BYTES; i++) begin
      if (rd_addr == BYTE_W'(32'(ADDR_MASK_BASE) + i)) rd_data = mask_q[i];
    end
  end

  assign div_n    = div_q;
  assign base_sel = |sel_q;
  assign reload   = wr_en && ((wr_addr == ADDR_DIV) || (wr_addr == ADDR_SEL));

  // R4
  mask_lo_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr == ADDR_MASK_BASE |=> chan_mask[BYTE_W-1:0] == $past(wr_data));

endmodule

// File: rtl/lacfg_divider.sv
module lacfg_divider #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             base_sel,
  input  logic [CNT_W-1:0] div_n,
  input  logic             reload,
  output logic             strobe
);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_sel;

  assign tick_sel = base_sel ? tick_fast : tick_slow;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      strobe <= 1'b0;
    end else if (reload) begin
      cnt_q  <= '0;
      strobe <= 1'b0;
    end else if (tick_sel) begin
      if (cnt_q >= div_n) begin
        cnt_q  <= '0;
        strobe <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        strobe <= 1'b0;
      end
    end else begin
      strobe <= 1'b0;
    end
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= div_n);

  // R6
  stb_cause_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(tick_sel && !reload));

  // R8
  reload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> !strobe);

endmodule

// File: rtl/lacfg_top.sv
module lacfg_top
  import lacfg_pkg::*;
#(
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  input  logic              rsp_ready,
  input  logic              tick_slow,
  input  logic              tick_fast,
  output logic [MASK_W-1:0] chan_mask,
  output logic              sample_stb
);

  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_data;
  logic [BYTE_W-1:0] div_n;
  logic              base_sel;
  logic              reload;

  lacfg_parser u_parser (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (cmd_valid),
    .in_data   (cmd_data),
    .in_ready  (cmd_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_ready (rsp_ready)
  );

  lacfg_regfile #(.MASK_W(MASK_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .chan_mask (chan_mask),
    .div_n     (div_n),
    .base_sel  (base_sel),
    .reload    (reload)
  );

  lacfg_divider #(.CNT_W(BYTE_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .base_sel  (base_sel),
    .div_n     (div_n),
    .reload    (reload),
    .strobe    (sample_stb)
  );

endmodule

// File: tb/lacfg_top_bench.sv
module lacfg_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_data = '0;
  logic        cmd_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rsp_ready = 1'b1;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic [15:0] chan_mask;
  logic        sample_stb;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit auto_ticks = 1'b1;
  bit done = 1'b0;

  lacfg_top u_lacfg_top (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .chan_mask(chan_mask), .sample_stb(sample_stb)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // slow base pulses every 3rd cycle, fast base every 2nd cycle
  initial begin
    int p3 = 0;
    int p2 = 0;
    forever begin
      @(posedge clk);
      #1;
      if (auto_ticks) begin
        p3 = (p3 + 1) % 3;
        p2 = (p2 + 1) % 2;
        tick_slow = (p3 == 0);
        tick_fast = (p2 == 0);
      end
    end
  end

  // fields: mask_lo, mask_hi, select, N, expected mask, expected gap
  localparam int NV = 8;
  localparam logic [55:0] VEC [NV] = '{
    {8'h07, 8'h00, 8'h00, 8'h00, 16'h0007, 8'd3},
    {8'h3f, 8'h00, 8'h00, 8'h01, 16'h003f, 8'd6},
    {8'hff, 8'h01, 8'h01, 8'h01, 16'h01ff, 8'd4},
    {8'hff, 8'hff, 8'h01, 8'h13, 16'hffff, 8'd40},
    {8'h55, 8'haa, 8'h00, 8'h09, 16'haa55, 8'd30},
    {8'h00, 8'h80, 8'h01, 8'h04, 16'h8000, 8'd10},
    {8'h01, 8'h00, 8'h01, 8'h00, 16'h0001, 8'd2},
    {8'h80, 8'h7f, 8'h00, 8'h07, 16'h7f80, 8'd24}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    int guard = 0;
    cmd_valid = 1'b1;
    cmd_data  = b;
    while (!cmd_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    send_byte(8'h80); send_byte(8'h01); send_byte(a); send_byte(d);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    int guard = 0;
    send_byte(8'h81); send_byte(8'h01); send_byte(a);
    while (!rsp_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    d = rsp_data;
    @(negedge clk);
  endtask

  task automatic measure_gap(output int gap);
    int t0 = -1;
    int guard = 0;
    gap = -1;
    while (guard < 2000) begin
      @(negedge clk);
      guard++;
      if (sample_stb) begin
        if (t0 < 0) t0 = cyc;
        else begin
          gap = cyc - t0;
          break;
        end
      end
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int g;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    check(chan_mask == 16'h0, "R9", "mask after reset", chan_mask, 0);
    check(cmd_ready == 1'b1, "R9", "cmd_ready after reset", cmd_ready, 1);
    check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
    measure_gap(g);
    check(g == 3, "R9", "default gap on slow base", g, 3);
    rd_reg(8'h04, r);
    check(r == 8'h00, "R9", "divide reg after reset", r, 0);
    rd_reg(8'h0a, r);
    check(r == 8'h00, "R9", "select reg after reset", r, 0);

    // vector table: R4 mask, R2 read-back, R6/R7 strobe spacing
    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      wr_reg(8'h02, v[55:48]);
      wr_reg(8'h03, v[47:40]);
      wr_reg(8'h0a, v[39:32]);
      wr_reg(8'h04, v[31:24]);
      check(chan_mask == v[23:8], "R4", $sformatf("vec %0d mask", i), chan_mask, v[23:8]);
      rd_reg(8'h04, r);
      check(r == v[31:24], "R2", $sformatf("vec %0d divide read-back", i), r, v[31:24]);
      measure_gap(g);
      check(g == int'(v[7:0]), v[32] ? "R7" : "R6", $sformatf("vec %0d strobe gap", i), g, v[7:0]);
    end

    // R1: no update before the data byte
    wr_reg(8'h02, 8'h11);
    send_byte(8'h80); send_byte(8'h01); send_byte(8'h02);
    repeat (3) @(negedge clk);
    check(chan_mask[7:0] == 8'h11, "R1", "mask before data byte", chan_mask[7:0], 8'h11);
    send_byte(8'h9c);
    check(chan_mask[7:0] == 8'h9c, "R1", "mask after data byte", chan_mask[7:0], 8'h9c);

    // R2: unmapped address reads zero; R4: unmapped write has no effect
    wr_reg(8'h07, 8'hee);
    rd_reg(8'h07, r);
    check(r == 8'h00, "R2", "unmapped read", r, 0);
    check(chan_mask == 16'h7f9c, "R4", "mask after unmapped write", chan_mask, 16'h7f9c);

    // R5: garbage, bad second byte, restarting opcodes
    send_byte(8'h33); send_byte(8'h80); send_byte(8'h05);
    wr_reg(8'h02, 8'h5a);
    check(chan_mask[7:0] == 8'h5a, "R5", "write after resync", chan_mask[7:0], 8'h5a);
    send_byte(8'h80); send_byte(8'h81); send_byte(8'h01); send_byte(8'h03);
    check(rsp_valid == 1'b1 && rsp_data == 8'h7f, "R5", "read started by second byte", rsp_data, 8'h7f);
    @(negedge clk);
    send_byte(8'h81); send_byte(8'h80); send_byte(8'h01); send_byte(8'h02); send_byte(8'hc3);
    check(chan_mask[7:0] == 8'hc3, "R5", "write started by second byte", chan_mask[7:0], 8'hc3);
    check(rsp_valid == 1'b0, "R5", "no reply from aborted read", rsp_valid, 0);

    // R3: backpressure on reply
    rsp_ready = 1'b0;
    send_byte(8'h81); send_byte(8'h01); send_byte(8'h03);
    cmd_valid = 1'b1; cmd_data = 8'h80;
    repeat (4) @(negedge clk);
    check(rsp_valid == 1'b1, "R3", "reply pending held", rsp_valid, 1);
    check(rsp_data == 8'h7f, "R3", "reply data held", rsp_data, 8'h7f);
    check(cmd_ready == 1'b0, "R3", "cmd_ready low while pending", cmd_ready, 0);
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && cmd_ready == 1'b1, "R3", "reply consumed", rsp_valid, 0);

    // R8: tick coinciding with reload write is dropped
    auto_ticks = 1'b0;
    tick_fast = 1'b1;
    tick_slow = 1'b1;
    wr_reg(8'h0a, 8'h00);
    wr_reg(8'h04, 8'h02);
    begin
      logic s1, s2, s3;
      @(negedge clk); s1 = sample_stb;
      @(negedge clk); s2 = sample_stb;
      @(negedge clk); s3 = sample_stb;
      check(!s1 && !s2 && s3, "R8", "first strobe after reload", {s1, s2, s3}, 3'b001);
    end

    // R6: no base pulses, no strobe; R7: unselected base ignored
    tick_slow = 1'b0;
    tick_fast = 1'b1;
    wr_reg(8'h04, 8'h00);
    begin
      int n = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (sample_stb) n++;
      end
      check(n == 0, "R7", "strobes from unselected base", n, 0);
    end
    tick_fast = 1'b0;
    wr_reg(8'h0a, 8'h01);
    begin
      int n = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (sample_stb) n++;
      end
      check(n == 0, "R6", "strobes with no base pulses", n, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule